// File: doc/BRIEF.md
# MOV Instruction Field and Length Decoder

This block takes a stream of instruction bytes, one per accepted cycle under a valid/ready handshake, and splits 16-bit real-mode data-move instructions into their fields. It handles five forms: register/memory moves with a mode byte, immediate-to-register moves, accumulator moves to or from a direct address, immediate-to-memory moves, and moves to or from a segment register. Because the length of an instruction depends on its opcode and on the mode byte, the block counts bytes as they arrive. It decides on the fly which byte ends the instruction, which may be anywhere from the first to the sixth.

When the last byte of an instruction has been accepted, the block raises a one-cycle decoded pulse. With the pulse it presents the operation class, the direction and width bits, the three mode-byte fields, the displacement, the immediate value and the total byte count. Forms it does not recognise, and illegal segment selections, are flagged rather than decoded. A pipeline front end would place it between an instruction byte queue and the operand fetch logic.

Top module: `mov_decoder`

## Requirements
- R1: While reset is held, `in_ready` and `dec_valid` are low. From the first clock after reset, `in_ready` stays high, so every cycle with `in_valid` high accepts one byte.
- R2: `dec_valid` is high for exactly the one cycle after the edge that accepted an instruction's last byte, and is low after every other byte. `dec_len` gives the byte count. Without a displacement, the lengths are: 2 for the mode-byte forms (88h-8Bh, 8Ch, 8Eh); 2 or 3 for B0h-B7h or B8h-BFh; 3 for A0h-A3h; 3 or 4 for C6h or C7h. A displacement adds 1 byte when MOD=01, and 2 bytes when MOD=10 or when MOD=00 with R/M=110.
- R3: `dec_d` is opcode bit 1 for 88h-8Bh, 8Ch and 8Eh, where 1 means data flows into the REG operand. It is 1 for B0h-BFh, 1 for A0h/A1h (load into the accumulator), 0 for A2h/A3h, and 0 for C6h/C7h.
- R4: `dec_w` (1 = word, 0 = byte) is opcode bit 0 for 88h-8Bh, A0h-A3h and C6h/C7h, opcode bit 3 for B0h-BFh, and 1 for segment moves.
- R5: For the mode-byte forms, `dec_mod`, `dec_reg` and `dec_rm` are mode-byte bits 7:6, 5:3 and 2:0. For B0h-BFh, MOD reads 11 and REG and R/M both equal opcode bits 2:0. For A0h-A3h, MOD reads 00, REG reads 000 and R/M reads 110. The register name is the entry at index REG in AL,CL,DL,BL,AH,CH,DH,BH when W=0, or in AX,CX,DX,BX,SP,BP,SI,DI when W=1.
- R6: Multi-byte fields arrive low byte first. A one-byte displacement is sign-extended to 16 bits. A two-byte displacement is taken as is, and A0h-A3h carry theirs in bytes 2-3. With no displacement, `dec_disp` is zero.
- R7: `dec_imm` is the data byte (zero-extended) or data word that follows the opcode for B0h-BFh. For C6h/C7h, it is the data that follows the displacement. It is zero for the other forms.
- R8: `dec_class` is 0 for a register/memory move, 1 for a segment move, 2 for immediate-to-register, 3 for accumulator direct, 4 for immediate-to-memory and 7 for an unsupported opcode.
- R9: An unsupported opcode gives `dec_illegal`=1, class 7 and length 1. For a segment move, a REG code of 110 or 111, or REG=001 (CS) as the destination with opcode 8Eh, gives `dec_illegal`=1 and ends the instruction at the mode byte, with length 2.
- R10: The byte pair 8Bh ECh decodes as a word move from SP into BP, and 8Ah 15h decodes as a byte move into DL from the memory addressed by DI without a displacement.
- R11: A new instruction's first byte may arrive in the cycle right after a last byte. A cycle with `in_valid` low neither advances nor ends the instruction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction byte is presented |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | The block accepts a byte this cycle |
| dec_valid | output | 1 | One-cycle pulse: a decoded instruction is presented |
| dec_class | output | 3 | Operation class (R8) |
| dec_illegal | output | 1 | Unsupported or illegal form |
| dec_d | output | 1 | Direction bit |
| dec_w | output | 1 | Width bit |
| dec_mod | output | 2 | MOD field |
| dec_reg | output | 3 | REG field (segment code for segment moves) |
| dec_rm | output | 3 | R/M field |
| dec_disp | output | 16 | Displacement |
| dec_imm | output | 16 | Immediate data |
| dec_len | output | 3 | Instruction length in bytes |

## Verification
The assertions assume that bytes belong to a single well-formed instruction stream: no byte is skipped, and the stream never starts mid-instruction after reset, so the checker's own byte count lines up with instruction boundaries. The stimulus meets this by always sending each instruction in full, to the length that the bench model computes. The stimulus sweeps every opcode and, for each mode-byte opcode, every mode byte. It inserts idle cycles inside some instructions and sends the rest back to back.

// File: rtl/movdec_pkg.sv
`timescale 1ns/1ps
package movdec_pkg;

  localparam int MAX_LEN = 6;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int WIN_W   = MAX_LEN * 8;

  typedef enum logic [2:0] {
    CLS_RM     = 3'd0,
    CLS_SEG    = 3'd1,
    CLS_IMMREG = 3'd2,
    CLS_ACC    = 3'd3,
    CLS_IMMMEM = 3'd4,
    CLS_BAD    = 3'd7
  } op_class_e;

  typedef struct packed {
    op_class_e        cls;
    logic             illegal;
    logic             d;
    logic             w;
    logic [1:0]       md;
    logic [2:0]       rg;
    logic [2:0]       rm;
    logic [15:0]      disp;
    logic [15:0]      imm;
    logic [LEN_W-1:0] len;
  } dec_t;

  function automatic op_class_e classify(logic [7:0] op);
    case (op) inside
      8'h88, 8'h89, 8'h8A, 8'h8B: return CLS_RM;
      8'h8C, 8'h8E:               return CLS_SEG;
      [8'hB0:8'hBF]:              return CLS_IMMREG;
      [8'hA0:8'hA3]:              return CLS_ACC;
      8'hC6, 8'hC7:               return CLS_IMMMEM;
      default:                    return CLS_BAD;
    endcase
  endfunction

  function automatic logic has_mrm(op_class_e c);
    return (c == CLS_RM) || (c == CLS_SEG) || (c == CLS_IMMMEM);
  endfunction

  // Displacement bytes implied by MOD and R/M.
  function automatic logic [LEN_W-1:0] disp_bytes(logic [1:0] md, logic [2:0] rm);
    if (md == 2'b01) return LEN_W'(1);
    if (md == 2'b10) return LEN_W'(2);
    if (md == 2'b00 && rm == 3'b110) return LEN_W'(2);
    return '0;
  endfunction

  // Length not counting any displacement.
  function automatic logic [LEN_W-1:0] fixed_len(logic [7:0] op);
    case (classify(op))
      CLS_RM, CLS_SEG: return LEN_W'(2);
      CLS_IMMREG:      return op[3] ? LEN_W'(3) : LEN_W'(2);
      CLS_ACC:         return LEN_W'(3);
      CLS_IMMMEM:      return op[0] ? LEN_W'(4) : LEN_W'(3);
      default:         return LEN_W'(1);
    endcase
  endfunction

  // Segment code outside the six defined, or CS written.
  function automatic logic seg_illegal(logic into_seg, logic [2:0] rg);
    return (rg[2:1] == 2'b11) || (into_seg && rg == 3'b001);
  endfunction

endpackage

// File: rtl/movdec_collect.sv
`timescale 1ns/1ps
module movdec_collect
  import movdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [7:0]       in_byte,
  output logic             last_byte,
  output logic [WIN_W-1:0] win
);

  logic [LEN_W-1:0] cnt_q;
  logic [7:0]       store_q [MAX_LEN];
  op_class_e        op_cls;
  logic             mrm_form;
  logic             stop_early;
  logic [LEN_W-1:0] need;

  // Byte window: earlier bytes from storage, the current one from the input.
  generate
    for (genvar gi = 0; gi < MAX_LEN; gi++) begin : g_win
      assign win[gi*8 +: 8] = (cnt_q == LEN_W'(gi)) ? in_byte : store_q[gi];
    end
  endgenerate

  always_comb begin
    op_cls     = classify(win[7:0]);
    mrm_form   = has_mrm(op_cls);
    need       = fixed_len(win[7:0]) +
                 (mrm_form ? disp_bytes(win[15:14], win[10:8]) : '0);
    stop_early = (op_cls == CLS_SEG) && (cnt_q == LEN_W'(1)) &&
                 seg_illegal(win[1], win[13:11]);
    last_byte  = accept && (stop_early ||
                 ((cnt_q != '0 || !mrm_form) && (cnt_q + LEN_W'(1) == need)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < MAX_LEN; i++) store_q[i] <= '0;
    end else if (accept) begin
      store_q[cnt_q] <= in_byte;
      cnt_q          <= last_byte ? '0 : cnt_q + LEN_W'(1);
    end
  end

endmodule

// File: rtl/movdec_fields.sv
`timescale 1ns/1ps
module movdec_fields
  import movdec_pkg::*;
(
  input  logic [WIN_W-1:0] win,
  output dec_t             dec
);

  function automatic logic [7:0] pick(logic [WIN_W-1:0] w, int idx);
    return w[idx*8 +: 8];
  endfunction

  logic [7:0]       op, mrm;
  op_class_e        cls;
  logic [LEN_W-1:0] dl;
  logic             bad_seg;
  int               ip;

  always_comb begin
    op      = pick(win, 0);
    mrm     = pick(win, 1);
    cls     = classify(op);
    dl      = has_mrm(cls) ? disp_bytes(mrm[7:6], mrm[2:0]) : '0;
    bad_seg = (cls == CLS_SEG) && seg_illegal(op[1], mrm[5:3]);
    ip      = 2 + int'(dl);
    dec     = '0;
    dec.cls = cls;
    case (cls)
      CLS_RM, CLS_SEG, CLS_IMMMEM: begin
        dec.d  = (cls == CLS_IMMMEM) ? 1'b0 : op[1];
        dec.w  = (cls == CLS_SEG) ? 1'b1 : op[0];
        dec.md = mrm[7:6];
        dec.rg = mrm[5:3];
        dec.rm = mrm[2:0];
        if (dl == LEN_W'(1))
          dec.disp = {{8{win[23]}}, win[23:16]};
        else if (dl == LEN_W'(2))
          dec.disp = win[31:16];
        if (cls == CLS_IMMMEM)
          dec.imm = {op[0] ? pick(win, ip + 1) : 8'h00, pick(win, ip)};
      end
      CLS_IMMREG: begin
        dec.d   = 1'b1;
        dec.w   = op[3];
        dec.md  = 2'b11;
        dec.rg  = op[2:0];
        dec.rm  = op[2:0];
        dec.imm = {op[3] ? win[23:16] : 8'h00, win[15:8]};
      end
      CLS_ACC: begin
        dec.d    = ~op[1];
        dec.w    = op[0];
        dec.rm   = 3'b110;
        dec.disp = win[23:8];
      end
      default: ;
    endcase
    dec.illegal = (cls == CLS_BAD) || bad_seg;
    if (cls == CLS_BAD) dec.len = LEN_W'(1);
    else if (bad_seg) begin
      dec.len  = LEN_W'(2);
      dec.disp = '0;
    end else dec.len = fixed_len(op) + dl;
  end

endmodule

// File: rtl/mov_decoder.sv
`timescale 1ns/1ps
module mov_decoder
  import movdec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_ready,
  output logic        dec_valid,
  output logic [2:0]  dec_class,
  output logic        dec_illegal,
  output logic        dec_d,
  output logic        dec_w,
  output logic [1:0]  dec_mod,
  output logic [2:0]  dec_reg,
  output logic [2:0]  dec_rm,
  output logic [15:0] dec_disp,
  output logic [15:0] dec_imm,
  output logic [2:0]  dec_len
);

  logic             ready_q;
  logic             accept;
  logic             last_byte;
  logic [WIN_W-1:0] win;
  dec_t             dec_now;
  dec_t             dec_q;
  logic             valid_q;

  assign accept = in_valid && ready_q;

  movdec_collect u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .in_byte   (in_byte),
    .last_byte (last_byte),
    .win       (win)
  );

  movdec_fields u_fields (
    .win (win),
    .dec (dec_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      valid_q <= 1'b0;
      dec_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      valid_q <= last_byte;
      if (last_byte) dec_q <= dec_now;
    end
  end

  assign in_ready    = ready_q;
  assign dec_valid   = valid_q;
  assign dec_class   = dec_q.cls;
  assign dec_illegal = dec_q.illegal;
  assign dec_d       = dec_q.d;
  assign dec_w       = dec_q.w;
  assign dec_mod     = dec_q.md;
  assign dec_reg     = dec_q.rg;
  assign dec_rm      = dec_q.rm;
  assign dec_disp    = dec_q.disp;
  assign dec_imm     = dec_q.imm;
  assign dec_len     = dec_q.len;

endmodule

// File: rtl/mov_decoder_chk.sv
`timescale 1ns/1ps
module mov_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        last_byte,
  input logic        dec_valid,
  input logic [2:0]  dec_class,
  input logic        dec_illegal,
  input logic        dec_w,
  input logic [1:0]  dec_mod,
  input logic [15:0] dec_disp,
  input logic [15:0] dec_imm,
  input logic [2:0]  dec_len
);

  logic [2:0] run_cnt;
  logic [2:0] done_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      done_len <= '0;
    end else if (in_valid && in_ready) begin
      run_cnt <= last_byte ? 3'd0 : run_cnt + 3'd1;
      if (last_byte) done_len <= run_cnt + 3'd1;
    end
  end

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_ready) |-> in_ready);

  // R2
  len_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> dec_len == done_len);

  // R2
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_len >= 3'd1 && dec_len <= 3'd6));

  // R2
  reg_form_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_class == 3'd0 && dec_mod == 2'b11) |-> dec_len == 3'd2);

  // R6
  disp_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_illegal && dec_class == 3'd0 && dec_mod == 2'b01)
      |-> dec_disp[15:8] == {8{dec_disp[7]}});

  // R7
  imm_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_class == 3'd4 && !dec_w) |-> dec_imm[15:8] == 8'h00);

  // R9
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_class == 3'd7) |-> (dec_illegal && dec_len == 3'd1));

endmodule

bind mov_decoder mov_decoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .last_byte   (last_byte),
  .dec_valid   (dec_valid),
  .dec_class   (dec_class),
  .dec_illegal (dec_illegal),
  .dec_w       (dec_w),
  .dec_mod     (dec_mod),
  .dec_disp    (dec_disp),
  .dec_imm     (dec_imm),
  .dec_len     (dec_len)
);

// File: tb/mov_decoder_tb_top.sv
`timescale 1ns/1ps
module mov_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_byte;
  logic        in_ready;
  logic        dec_valid;
  logic [2:0]  dec_class;
  logic        dec_illegal;
  logic        dec_d;
  logic        dec_w;
  logic [1:0]  dec_mod;
  logic [2:0]  dec_reg;
  logic [2:0]  dec_rm;
  logic [15:0] dec_disp;
  logic [15:0] dec_imm;
  logic [2:0]  dec_len;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mov_decoder dut_i (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Independent reference: fields worked out from the requirement text.
  task automatic model(input logic [7:0] b [6],
                       output int cls, output int ill, output int ln,
                       output int d, output int w, output int md,
                       output int rg, output int rm,
                       output int disp, output int imm);
    int op, m, dl, p;
    bit segbad;
    op = b[0]; m = b[1];
    md = m / 64; rg = (m / 8) % 8; rm = m % 8;
    if (op >= 'h88 && op <= 'h8B) cls = 0;
    else if (op == 'h8C || op == 'h8E) cls = 1;
    else if (op >= 'hB0 && op <= 'hBF) cls = 2;
    else if (op >= 'hA0 && op <= 'hA3) cls = 3;
    else if (op == 'hC6 || op == 'hC7) cls = 4;
    else cls = 7;
    dl = (md == 1) ? 1 : (md == 2) ? 2 : (md == 0 && rm == 6) ? 2 : 0;
    segbad = (cls == 1) && (rg >= 6 || (op == 'h8E && rg == 1));
    ill = (cls == 7 || segbad) ? 1 : 0;
    disp = 0; imm = 0; d = 0; w = 0;
    case (cls)
      0, 1: begin ln = 2 + dl; d = (op / 2) % 2; w = (cls == 1) ? 1 : op % 2; end
      2: begin
        w = (op / 8) % 2; d = 1; ln = w ? 3 : 2; md = 3; rg = op % 8; rm = op % 8;
        imm = w ? b[2] * 256 + b[1] : b[1];
      end
      3: begin
        ln = 3; w = op % 2; d = (op < 'hA2) ? 1 : 0; md = 0; rg = 0; rm = 6;
        disp = b[2] * 256 + b[1];
      end
      4: begin
        w = op % 2; ln = 2 + dl + 1 + w; d = 0;
        p = 2 + dl;
        imm = w ? b[p+1] * 256 + b[p] : b[p];
      end
      default: ln = 1;
    endcase
    if (cls == 0 || cls == 1 || cls == 4) begin
      if (dl == 1) disp = (b[2] >= 128) ? ('hFF00 + b[2]) : b[2];
      if (dl == 2) disp = b[3] * 256 + b[2];
    end
    if (segbad) ln = 2;
  endtask

  // Sends one instruction from the current negedge; ends at the negedge
  // where its result is sampled, leaving in_valid low.
  task automatic send(input logic [7:0] b [6], input bit gap);
    int cls, ill, ln, d, w, md, rg, rm, disp, imm;
    model(b, cls, ill, ln, d, w, md, rg, rm, disp, imm);
    for (int i = 0; i < ln; i++) begin
      if (i > 0) begin
        @(negedge clk);
        chk("R2 no pulse mid-instruction", dec_valid, 0);
      end
      in_valid = 1'b1;
      in_byte  = b[i];
      if (gap && i == 0 && ln > 1) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'hC6;
        @(negedge clk);
        chk("R11 idle cycle does not end instruction", dec_valid, 0);
        in_valid = 1'b1;
        in_byte  = b[1];
        i = 1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 pulse after last byte", dec_valid, 1);
    chk("R2 length", dec_len, ln);
    chk("R8 class", dec_class, cls);
    chk("R9 illegal flag", dec_illegal, ill);
    if (!ill) begin
      chk("R3 direction", dec_d, d);
      chk("R4 width", dec_w, w);
      chk("R5 mod", dec_mod, md);
      chk("R5 reg", dec_reg, rg);
      chk("R5 rm", dec_rm, rm);
      chk("R6 displacement", dec_disp, disp);
      chk("R7 immediate", dec_imm, imm);
    end
  endtask

  initial begin
    logic [7:0] b [6];
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", in_ready, 0);
    chk("R1 no pulse in reset", dec_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", in_ready, 1);
    chk("R1 no pulse after reset", dec_valid, 0);

    // R10: word move SP -> BP
    b = '{8'h8B, 8'hEC, 8'h00, 8'h00, 8'h00, 8'h00};
    send(b, 1'b0);
    chk("R10 BP,SP reg is BP (101)", dec_reg, 5);
    chk("R10 BP,SP rm is SP (100)", dec_rm, 4);
    chk("R10 BP,SP word", dec_w, 1);
    // R10: byte move [DI] -> DL
    b = '{8'h8A, 8'h15, 8'h00, 8'h00, 8'h00, 8'h00};
    send(b, 1'b0);
    chk("R10 DL,[DI] reg is DL (010)", dec_reg, 2);
    chk("R10 DL,[DI] rm is DI (101)", dec_rm, 5);
    chk("R10 DL,[DI] mod 00", dec_mod, 0);
    chk("R10 DL,[DI] byte", dec_w, 0);
    chk("R10 DL,[DI] length", dec_len, 2);

    // Sweep every opcode; every mode byte for the mode-byte forms. R11 back to back.
    for (int op = 0; op < 256; op++) begin
      if (op inside {'h88, 'h89, 'h8A, 'h8B, 'h8C, 'h8E, 'hC6, 'hC7}) begin
        for (int m = 0; m < 256; m++) begin
          b[0] = 8'(op); b[1] = 8'(m);
          b[2] = 8'(m ^ 'hA5); b[3] = 8'(op ^ 'h3C);
          b[4] = 8'(m + 1);    b[5] = 8'(~m);
          send(b, (m % 7) == 0);
        end
      end else begin
        b[0] = 8'(op); b[1] = 8'(op ^ 'h9C); b[2] = 8'(op + 'h61);
        b[3] = 8'h00; b[4] = 8'h00; b[5] = 8'h00;
        send(b, (op % 5) == 0);
      end
    end

    @(negedge clk);
    chk("R2 no pulse when idle", dec_valid, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule